// File: doc/BRIEF.md
# Two-Thread Banked Register File

This block is the general-purpose register store for a processor core that runs two hardware threads in alternation. It holds 64 words of 32 bits, split into two banks of 32. One bank belongs to each thread. A one-bit read-thread input is placed above the 5-bit register number to form a 6-bit storage address. The read side therefore sees only the bank of the thread being decoded.

Each instruction can name up to three registers, so the file has three combinational read ports. They are the first operand, the second operand and the destination operand, which a store needs to read. The storage is replicated once per read port. Every copy receives the same synchronous write address, data and enable, so the copies always hold identical contents.

The write port has its own thread input. A write-back from a later pipeline stage can therefore land in either bank, whatever thread is being read in that cycle. Register 0 of each bank reads as zero and cannot be written. The storage has no reset. While the asynchronous active-low reset is asserted, and for two clock edges after it is released, writes are blocked.

Top module: `thr_bank_regfile`

## Requirements
- R1: After a write with `wr_en`=1 to register n≠0 of thread t, every read port whose address is n while `rd_thread`=t returns the written data. The new data appears directly after the writing rising edge.
- R2: A write to register n of one thread leaves register n of the other thread unchanged.
- R3: `rd_thread` selects the bank for all three read ports. Value 0 reads bank 0 and value 1 reads bank 1, so `rd_thread` acts as storage address bit 5 above the 5-bit register number.
- R4: The bank written is chosen only by `wr_thread`, independently of `rd_thread` in the same cycle.
- R5: The three read ports are independent. Each port returns the register it addresses, and ports with equal addresses return equal data.
- R6: A read of register 0 returns 0 on any port in either bank. A write to register 0 has no effect.
- R7: There is no write-to-read bypass. While a write to register n is pending before its clock edge, a read of register n returns the old value.
- R8: A clock edge with `wr_en`=0 changes no register.
- R9: No write takes effect while `rst_n` is 0, nor at the first two rising edges after `rst_n` returns to 1. Writes take effect from the third edge on. Reset does not alter stored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; gates writes, does not clear storage |
| rd_thread | input | 1 | Bank selected for all read ports |
| rd_a_addr | input | 5 | Register number for the first operand port |
| rd_b_addr | input | 5 | Register number for the second operand port |
| rd_d_addr | input | 5 | Register number for the destination operand port |
| wr_thread | input | 1 | Bank targeted by the write |
| wr_addr | input | 5 | Register number written |
| wr_data | input | 32 | Data written |
| wr_en | input | 1 | Write enable |
| rd_a_data | output | 32 | First operand read data |
| rd_b_data | output | 32 | Second operand read data |
| rd_d_data | output | 32 | Destination operand read data |

## Verification
The same register number is written with different values in the two banks. This separates correct bank isolation from a design that ignores the thread bit on either the read side or the write side. Separate writes with the write thread opposite the read thread show whether the write side is tied to the read thread. The three ports are read together at distinct addresses and at a shared address, which exposes a port wired to the wrong copy or the wrong address. Register 0 writes and reads, a write pending before its edge, a cycle with the enable low, and writes around reset release each test one gating condition.

// File: rtl/thr_rf_pkg.sv
package thr_rf_pkg;
  localparam int unsigned DEF_DATA_W  = 32;
  localparam int unsigned DEF_REG_W   = 5;
  localparam int unsigned DEF_THR_W   = 1;
  localparam int unsigned DEF_PORTS   = 3;
  localparam int unsigned DEF_SYNC_ST = 2;

  // port roles, in the order of the packed read buses inside the top
  typedef enum logic [1:0] {
    PORT_OPA = 2'd0,
    PORT_OPB = 2'd1,
    PORT_OPD = 2'd2
  } rd_port_e;
endpackage

// File: rtl/thr_rf_rst_sync.sv
module thr_rf_rst_sync #(
  parameter int unsigned STAGES = thr_rf_pkg::DEF_SYNC_ST
) (
  input  logic clk,
  input  logic rst_n,
  output logic live
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign live = sync_q[STAGES-1];
endmodule

// File: rtl/thr_rf_wr_ctrl.sv
module thr_rf_wr_ctrl #(
  parameter int unsigned REG_W = thr_rf_pkg::DEF_REG_W,
  parameter int unsigned THR_W = thr_rf_pkg::DEF_THR_W,
  parameter int unsigned DATA_W = thr_rf_pkg::DEF_DATA_W,
  localparam int unsigned AW = REG_W + THR_W
) (
  input  logic              live,
  input  logic [THR_W-1:0]  wr_thread,
  input  logic [REG_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en,
  output logic              mem_we,
  output logic [AW-1:0]     mem_wa,
  output logic [DATA_W-1:0] mem_wd
);
  logic reg_nonzero;

  always_comb begin
    reg_nonzero = |wr_addr;
    mem_we      = wr_en & live & reg_nonzero;
    mem_wa      = {wr_thread, wr_addr};
    mem_wd      = wr_data;
  end
endmodule

// File: rtl/thr_rf_mem.sv
module thr_rf_mem #(
  parameter int unsigned AW = thr_rf_pkg::DEF_REG_W + thr_rf_pkg::DEF_THR_W,
  parameter int unsigned DATA_W = thr_rf_pkg::DEF_DATA_W,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [AW-1:0]     ra,
  output logic [DATA_W-1:0] rd
);
  logic [DATA_W-1:0] store [DEPTH];

  // storage carries no reset: the word contents are undefined until written
  always_ff @(posedge clk) begin
    if (we) store[wa] <= wd;
  end

  assign rd = store[ra];
endmodule

// File: rtl/thr_rf_rd_port.sv
module thr_rf_rd_port #(
  parameter int unsigned REG_W = thr_rf_pkg::DEF_REG_W,
  parameter int unsigned THR_W = thr_rf_pkg::DEF_THR_W,
  parameter int unsigned DATA_W = thr_rf_pkg::DEF_DATA_W,
  localparam int unsigned AW = REG_W + THR_W
) (
  input  logic [THR_W-1:0]  thread,
  input  logic [REG_W-1:0]  reg_no,
  output logic [AW-1:0]     mem_ra,
  input  logic [DATA_W-1:0] mem_rd,
  output logic [DATA_W-1:0] data
);
  always_comb begin
    mem_ra = {thread, reg_no};
    data   = (|reg_no) ? mem_rd : '0;
  end
endmodule

// File: rtl/thr_bank_regfile.sv
module thr_bank_regfile #(
  parameter int unsigned DATA_W = thr_rf_pkg::DEF_DATA_W,
  parameter int unsigned REG_W  = thr_rf_pkg::DEF_REG_W,
  parameter int unsigned THR_W  = thr_rf_pkg::DEF_THR_W,
  parameter int unsigned SYNC_ST = thr_rf_pkg::DEF_SYNC_ST
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [THR_W-1:0]  rd_thread,
  input  logic [REG_W-1:0]  rd_a_addr,
  input  logic [REG_W-1:0]  rd_b_addr,
  input  logic [REG_W-1:0]  rd_d_addr,
  input  logic [THR_W-1:0]  wr_thread,
  input  logic [REG_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en,
  output logic [DATA_W-1:0] rd_a_data,
  output logic [DATA_W-1:0] rd_b_data,
  output logic [DATA_W-1:0] rd_d_data
);
  import thr_rf_pkg::*;
  localparam int unsigned PORTS = DEF_PORTS;
  localparam int unsigned AW = REG_W + THR_W;

  logic              wr_live;
  logic              mem_we;
  logic [AW-1:0]     mem_wa;
  logic [DATA_W-1:0] mem_wd;

  logic [REG_W-1:0]  port_reg  [PORTS];
  logic [AW-1:0]     port_ra   [PORTS];
  logic [DATA_W-1:0] port_raw  [PORTS];
  logic [DATA_W-1:0] port_data [PORTS];

  thr_rf_rst_sync #(.STAGES(SYNC_ST)) u_rsync (
    .clk(clk), .rst_n(rst_n), .live(wr_live)
  );

  thr_rf_wr_ctrl #(.REG_W(REG_W), .THR_W(THR_W), .DATA_W(DATA_W)) u_wctl (
    .live(wr_live), .wr_thread(wr_thread), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_en(wr_en),
    .mem_we(mem_we), .mem_wa(mem_wa), .mem_wd(mem_wd)
  );

  always_comb begin
    port_reg[PORT_OPA] = rd_a_addr;
    port_reg[PORT_OPB] = rd_b_addr;
    port_reg[PORT_OPD] = rd_d_addr;
  end

  // one full storage copy per read port, all fed by the shared write port
  for (genvar p = 0; p < PORTS; p++) begin : g_port
    thr_rf_rd_port #(.REG_W(REG_W), .THR_W(THR_W), .DATA_W(DATA_W)) u_rp (
      .thread(rd_thread), .reg_no(port_reg[p]), .mem_ra(port_ra[p]),
      .mem_rd(port_raw[p]), .data(port_data[p])
    );
    thr_rf_mem #(.AW(AW), .DATA_W(DATA_W)) u_copy (
      .clk(clk), .we(mem_we), .wa(mem_wa), .wd(mem_wd),
      .ra(port_ra[p]), .rd(port_raw[p])
    );
  end

  assign rd_a_data = port_data[PORT_OPA];
  assign rd_b_data = port_data[PORT_OPB];
  assign rd_d_data = port_data[PORT_OPD];
endmodule

// File: rtl/thr_rf_checker.sv
module thr_rf_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_W  = 5,
  parameter int unsigned THR_W  = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_live,
  input logic [THR_W-1:0]  rd_thread,
  input logic [REG_W-1:0]  rd_a_addr,
  input logic [REG_W-1:0]  rd_b_addr,
  input logic [REG_W-1:0]  rd_d_addr,
  input logic [THR_W-1:0]  wr_thread,
  input logic [REG_W-1:0]  wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_en,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [DATA_W-1:0] rd_b_data,
  input logic [DATA_W-1:0] rd_d_data
);
  // R6: register 0 reads zero on every port
  a_r6_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_a_addr == '0) |-> (rd_a_data == '0)) and
    ((rd_b_addr == '0) |-> (rd_b_data == '0)) and
    ((rd_d_addr == '0) |-> (rd_d_data == '0)));

  // R5: two copies addressed alike agree
  a_r5_ports_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_addr == rd_b_addr) |-> (rd_a_data == rd_b_data));

  // R5: destination port agrees with first operand port
  a_r5_dport_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_addr == rd_d_addr) |-> (rd_a_data == rd_d_data));

  // R8: no write enable and unchanged read address keep the read value
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!wr_en) && $stable(rd_thread) && $stable(rd_a_addr)) |-> $stable(rd_a_data));

  // R1: a committed write is visible after its edge
  a_r1_write_seen: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_live && wr_en && (wr_addr != '0)) &&
     (rd_thread == $past(wr_thread)) && (rd_a_addr == $past(wr_addr)))
    |-> (rd_a_data == $past(wr_data)));

  // R9: nothing is committed before the write path is live
  a_r9_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!wr_live) && $stable(rd_thread) && $stable(rd_b_addr)) |-> $stable(rd_b_data));
endmodule

bind thr_bank_regfile thr_rf_checker #(.DATA_W(DATA_W), .REG_W(REG_W), .THR_W(THR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_live(wr_live), .rd_thread(rd_thread),
  .rd_a_addr(rd_a_addr), .rd_b_addr(rd_b_addr), .rd_d_addr(rd_d_addr),
  .wr_thread(wr_thread), .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en),
  .rd_a_data(rd_a_data), .rd_b_data(rd_b_data), .rd_d_data(rd_d_data)
);

// File: tb/thr_bank_regfile_test.sv
`timescale 1ns/1ps
module thr_bank_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_thread, wr_thread, wr_en;
  logic [4:0]  rd_a_addr, rd_b_addr, rd_d_addr, wr_addr;
  logic [31:0] wr_data;
  logic [31:0] rd_a_data, rd_b_data, rd_d_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  thr_bank_regfile uut (
    .clk(clk), .rst_n(rst_n), .rd_thread(rd_thread),
    .rd_a_addr(rd_a_addr), .rd_b_addr(rd_b_addr), .rd_d_addr(rd_d_addr),
    .wr_thread(wr_thread), .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en),
    .rd_a_data(rd_a_data), .rd_b_data(rd_b_data), .rd_d_data(rd_d_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic th, input logic [4:0] r, input logic [31:0] d);
    @(negedge clk);
    wr_thread = th; wr_addr = r; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_read(input logic th, input logic [4:0] a, input logic [4:0] b, input logic [4:0] d);
    rd_thread = th; rd_a_addr = a; rd_b_addr = b; rd_d_addr = d;
    #1;
  endtask

  task automatic t_reset_state;
    set_read(1'b0, 5'd0, 5'd0, 5'd0);
    check("R6 reset port A", rd_a_data, 32'h0);
    check("R6 reset port B", rd_b_data, 32'h0);
    check("R6 reset port D", rd_d_data, 32'h0);
  endtask

  task automatic t_basic_write;   // R1
    do_write(1'b0, 5'd5, 32'hA5A5_1234);
    set_read(1'b0, 5'd5, 5'd5, 5'd5);
    check("R1 port A", rd_a_data, 32'hA5A5_1234);
    check("R1 port B", rd_b_data, 32'hA5A5_1234);
    check("R1 port D", rd_d_data, 32'hA5A5_1234);
  endtask

  task automatic t_banks;         // R2, R3
    do_write(1'b1, 5'd5, 32'h0BAD_F00D);
    set_read(1'b0, 5'd5, 5'd5, 5'd5);
    check("R2 bank0 untouched", rd_a_data, 32'hA5A5_1234);
    set_read(1'b1, 5'd5, 5'd5, 5'd5);
    check("R3 bank1 selected", rd_b_data, 32'h0BAD_F00D);
  endtask

  task automatic t_write_thread;  // R4
    rd_thread = 1'b0;
    do_write(1'b1, 5'd7, 32'h7777_0001);
    rd_thread = 1'b0;
    do_write(1'b0, 5'd7, 32'h7777_0000);
    set_read(1'b1, 5'd7, 5'd7, 5'd7);
    check("R4 write to bank1 with read thread 0", rd_d_data, 32'h7777_0001);
    set_read(1'b0, 5'd7, 5'd7, 5'd7);
    check("R4 write to bank0", rd_d_data, 32'h7777_0000);
  endtask

  task automatic t_ports;         // R5
    for (int i = 1; i < 32; i++) do_write(1'b1, 5'(i), 32'hC000_0000 + 32'(i));
    for (int i = 1; i < 30; i++) begin
      set_read(1'b1, 5'(i), 5'(i+1), 5'(i+2));
      check("R5 port A", rd_a_data, 32'hC000_0000 + 32'(i));
      check("R5 port B", rd_b_data, 32'hC000_0000 + 32'(i+1));
      check("R5 port D", rd_d_data, 32'hC000_0000 + 32'(i+2));
    end
  endtask

  task automatic t_zero;          // R6
    do_write(1'b0, 5'd0, 32'hFFFF_FFFF);
    do_write(1'b1, 5'd0, 32'hFFFF_FFFF);
    set_read(1'b0, 5'd0, 5'd0, 5'd0);
    check("R6 write ignored bank0", rd_a_data | rd_b_data | rd_d_data, 32'h0);
    set_read(1'b1, 5'd0, 5'd0, 5'd0);
    check("R6 write ignored bank1", rd_a_data | rd_b_data | rd_d_data, 32'h0);
  endtask

  task automatic t_no_bypass;     // R7
    do_write(1'b0, 5'd9, 32'h1111_1111);
    @(negedge clk);
    wr_thread = 1'b0; wr_addr = 5'd9; wr_data = 32'h2222_2222; wr_en = 1'b1;
    set_read(1'b0, 5'd9, 5'd9, 5'd9);
    check("R7 old value before edge", rd_a_data, 32'h1111_1111);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    check("R7 new value after edge", rd_a_data, 32'h2222_2222);
  endtask

  task automatic t_hold;          // R8
    @(negedge clk);
    wr_thread = 1'b0; wr_addr = 5'd9; wr_data = 32'hDEAD_0000; wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    set_read(1'b0, 5'd9, 5'd9, 5'd9);
    check("R8 disabled write no change", rd_b_data, 32'h2222_2222);
  endtask

  task automatic t_reset_block;   // R9
    do_write(1'b0, 5'd3, 32'h3333_0000);
    @(negedge clk);
    rst_n = 1'b0;
    wr_thread = 1'b0; wr_addr = 5'd3; wr_data = 32'h3333_FFFF; wr_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    set_read(1'b0, 5'd3, 5'd3, 5'd3);
    check("R9 blocked during reset", rd_a_data, 32'h3333_0000);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    #1;
    check("R9 blocked two edges after release", rd_a_data, 32'h3333_0000);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    check("R9 third edge writes", rd_a_data, 32'h3333_FFFF);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_thread = 1'b0; wr_addr = '0; wr_data = '0;
    rd_thread = 1'b0; rd_a_addr = '0; rd_b_addr = '0; rd_d_addr = '0;
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_basic_write();
    t_banks();
    t_write_thread();
    t_ports();
    t_zero();
    t_no_bypass();
    t_hold();
    t_reset_block();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule